// File: doc/BRIEF.md
# Angle to Output-Code Mapper

This block turns a raw absolute angle sample from a rotary position sensor into a code for an output DAC. It applies four static settings to each sample in a fixed order. First it can reverse the counting direction. Next it subtracts a programmable zero position. It can then stretch a fraction of a turn across the full output span, and finally it can compress the result into the middle 80% of the DAC range so that a fault can be told apart from a real angle at either rail.

Samples arrive with a valid flag. The result is registered and appears one clock later with its own valid flag. When no sample arrives, the last code is held. Two settings that only matter to the analog stage after the DAC, the amplifier gain source and the reference source, pass through the block untouched.

Top module: `angle_dac_mapper`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_code` is 0 after the next clock edge.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: A clock edge with `in_valid` low leaves `out_code` unchanged.
- R4: With `cfg_reverse` = 0 the raw angle is used as is. With `cfg_reverse` = 1 it is replaced by (2^W − angle) mod 2^W, so that the angle rises for the opposite direction of rotation.
- R5: `cfg_zero` is subtracted from the direction-corrected angle modulo 2^W, so an angle equal to the zero position yields 0 before range and clamp.
- R6: `cfg_range` selects the span of a full output sweep: 0 for a full turn, 1 for a half turn (×2), 2 for a quarter turn (×4), 3 for an eighth turn (×8). A scaled value above 2^W−1 saturates at 2^W−1.
- R7: With `cfg_clamp` = 0 the code is the value from R6. With `cfg_clamp` = 1 the code is L + floor(v·S / 2^W), where v is the value from R6, L = floor(2^W/10) and S = 2^W − 2L. For W = 10 this maps v onto 102 to 921.
- R8: `out_gain_int` and `out_ref_ext` follow `cfg_gain_int` and `cfg_ref_ext` combinationally, with no effect on `out_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Raw angle sample is valid |
| in_angle | input | W | Raw absolute angle |
| cfg_reverse | input | 1 | Reverse the counting direction |
| cfg_zero | input | W | Angle that maps to output zero |
| cfg_range | input | 2 | Span select: full, half, quarter or eighth turn |
| cfg_clamp | input | 1 | Compress the output into 10–90% of full scale |
| cfg_gain_int | input | 1 | Amplifier gain source, passed through |
| cfg_ref_ext | input | 1 | DAC reference source, passed through |
| out_valid | output | 1 | Output code is valid |
| out_code | output | W | DAC code |
| out_gain_int | output | 1 | Copy of cfg_gain_int |
| out_ref_ext | output | 1 | Copy of cfg_ref_ext |

## Verification
The bench builds the block with its default width W = 10. At that width every one of the 1024 raw angles can be swept under each direction, several zero positions, all four ranges and both clamp settings. This covers the wrap of the modular subtraction, the exact edge where each reduced range starts to saturate, and the clamp end points 102 and 921. Hold behaviour and the valid latency are checked on cycles where the raw angle changes but no valid flag accompanies it.

// File: rtl/angle_dac_mapper.sv
module angle_dac_mapper #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_angle,
  input  logic         cfg_reverse,
  input  logic [W-1:0] cfg_zero,
  input  logic [1:0]   cfg_range,
  input  logic         cfg_clamp,
  input  logic         cfg_gain_int,
  input  logic         cfg_ref_ext,
  output logic         out_valid,
  output logic [W-1:0] out_code,
  output logic         out_gain_int,
  output logic         out_ref_ext
);
  localparam int FULL    = 1 << W;
  localparam int CL_LO   = FULL / 10;
  localparam int CL_SPAN = FULL - 2 * CL_LO;
  localparam logic [W+2:0]   MAXV  = (W+3)'(FULL - 1);
  localparam logic [W-1:0]   LO_W  = W'(CL_LO);
  localparam logic [2*W-1:0] SPAN_W = (2*W)'(CL_SPAN);

  logic [W-1:0]   dir_ang, rel_ang, sat_ang, clamp_ang, next_code;
  logic [W+2:0]   scaled;
  logic [2*W-1:0] prod;

  assign dir_ang   = cfg_reverse ? (W'(0) - in_angle) : in_angle;
  assign rel_ang   = dir_ang - cfg_zero;
  assign scaled    = {3'b000, rel_ang} << cfg_range;
  assign sat_ang   = (scaled > MAXV) ? MAXV[W-1:0] : scaled[W-1:0];
  assign prod      = {{W{1'b0}}, sat_ang} * SPAN_W;
  assign clamp_ang = LO_W + prod[2*W-1:W];
  assign next_code = cfg_clamp ? clamp_ang : sat_ang;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= next_code;
    end
  end

  assign out_gain_int = cfg_gain_int;
  assign out_ref_ext  = cfg_ref_ext;
endmodule

module angle_dac_mapper_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_angle,
  input logic         cfg_reverse,
  input logic [W-1:0] cfg_zero,
  input logic         cfg_clamp,
  input logic         cfg_gain_int,
  input logic         out_valid,
  input logic [W-1:0] out_code,
  input logic         out_gain_int
);
  localparam int FULL  = 1 << W;
  localparam int CL_LO = FULL / 10;
  localparam int CL_HI = FULL - 1 - CL_LO;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_code == '0)); // R1
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_code)); // R3
  AST_ZERO_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_clamp && !cfg_reverse && in_angle == cfg_zero) |=> out_code == '0); // R5
  AST_CLAMP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_clamp) |=> (int'(out_code) >= CL_LO && int'(out_code) <= CL_HI)); // R7
  AST_PASS_GAIN: assert property (@(posedge clk) disable iff (!rst_n) out_gain_int == cfg_gain_int); // R8
endmodule

bind angle_dac_mapper angle_dac_mapper_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
  .cfg_reverse(cfg_reverse), .cfg_zero(cfg_zero), .cfg_clamp(cfg_clamp),
  .cfg_gain_int(cfg_gain_int), .out_valid(out_valid), .out_code(out_code),
  .out_gain_int(out_gain_int)
);

// File: tb/angle_dac_mapper_tb.sv
module angle_dac_mapper_tb;
  localparam int W = 10;
  localparam int FULL = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_angle = '0;
  logic cfg_reverse = 1'b0;
  logic [W-1:0] cfg_zero = '0;
  logic [1:0] cfg_range = 2'd0;
  logic cfg_clamp = 1'b0;
  logic cfg_gain_int = 1'b0;
  logic cfg_ref_ext = 1'b0;
  logic out_valid;
  logic [W-1:0] out_code;
  logic out_gain_int, out_ref_ext;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  angle_dac_mapper #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
    .cfg_reverse(cfg_reverse), .cfg_zero(cfg_zero), .cfg_range(cfg_range),
    .cfg_clamp(cfg_clamp), .cfg_gain_int(cfg_gain_int), .cfg_ref_ext(cfg_ref_ext),
    .out_valid(out_valid), .out_code(out_code),
    .out_gain_int(out_gain_int), .out_ref_ext(out_ref_ext)
  );

  function automatic int model(int raw, bit rev, int zero, int rng, bit clamp);
    int a, d, m, lo, span;
    a = rev ? (FULL - raw) % FULL : raw;
    d = (a - zero + FULL) % FULL;
    m = d * (1 << rng);
    if (m > FULL - 1) m = FULL - 1;
    if (clamp) begin
      lo = FULL / 10;
      span = FULL - 2 * lo;
      m = lo + (m * span) / FULL;
    end
    return m;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, int raw);
    @(negedge clk);
    in_valid = v;
    in_angle = W'(raw);
    @(posedge clk);
    #5;
  endtask

  task automatic sweep(string req, bit rev, int zero, int rng, bit clamp);
    cfg_reverse = rev; cfg_zero = W'(zero); cfg_range = 2'(rng); cfg_clamp = clamp;
    for (int a = 0; a < FULL; a++) begin
      step(1'b1, a);
      check(req, int'(out_code), model(a, rev, zero, rng, clamp));
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b1; in_angle = W'(300);
    @(posedge clk); #5;
    check("R1 valid", int'(out_valid), 0);
    check("R1 code", int'(out_code), 0);
    @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
  endtask

  task automatic t_direction();
    sweep("R4 forward", 1'b0, 0, 0, 1'b0);
    sweep("R4 reverse", 1'b1, 0, 0, 1'b0);
  endtask

  task automatic t_zero();
    sweep("R5 zero 1", 1'b0, 1, 0, 1'b0);
    sweep("R5 zero 1023", 1'b0, 1023, 0, 1'b0);
    sweep("R5 zero 500 rev", 1'b1, 500, 0, 1'b0);
  endtask

  task automatic t_ranges();
    sweep("R6 half", 1'b0, 100, 1, 1'b0);
    sweep("R6 quarter", 1'b1, 0, 2, 1'b0);
    sweep("R6 eighth", 1'b0, 900, 3, 1'b0);
    cfg_reverse = 1'b0; cfg_zero = '0; cfg_range = 2'd3; cfg_clamp = 1'b0;
    step(1'b1, 127); check("R6 edge 127", int'(out_code), 1016);
    step(1'b1, 128); check("R6 sat 128", int'(out_code), 1023);
  endtask

  task automatic t_clamp();
    sweep("R7 clamp full", 1'b0, 0, 0, 1'b1);
    sweep("R7 clamp quarter", 1'b1, 37, 2, 1'b1);
    cfg_reverse = 1'b0; cfg_zero = '0; cfg_range = 2'd0; cfg_clamp = 1'b1;
    step(1'b1, 0); check("R7 low end", int'(out_code), 102);
    step(1'b1, 1023); check("R7 high end", int'(out_code), 921);
  endtask

  task automatic t_hold_latency();
    cfg_reverse = 1'b0; cfg_zero = '0; cfg_range = 2'd0; cfg_clamp = 1'b0;
    step(1'b1, 555);
    check("R2 valid high", int'(out_valid), 1);
    check("R3 loaded", int'(out_code), 555);
    step(1'b0, 12);
    check("R2 valid low", int'(out_valid), 0);
    check("R3 held", int'(out_code), 555);
    cfg_range = 2'd2;
    step(1'b0, 900);
    check("R3 held cfg change", int'(out_code), 555);
    step(1'b1, 10);
    check("R2 valid back", int'(out_valid), 1);
    check("R3 new load", int'(out_code), 40);
  endtask

  task automatic t_passthrough();
    cfg_reverse = 1'b0; cfg_zero = '0; cfg_range = 2'd0; cfg_clamp = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cfg_gain_int = k[0]; cfg_ref_ext = k[1];
      in_valid = 1'b1; in_angle = W'(200 + k);
      #1;
      check("R8 gain", int'(out_gain_int), k & 1);
      check("R8 ref", int'(out_ref_ext), (k >> 1) & 1);
      @(posedge clk); #5;
      check("R8 code unaffected", int'(out_code), 200 + k);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_hold_latency();
    t_direction();
    t_zero();
    t_ranges();
    t_clamp();
    t_passthrough();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule